// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block sits next to a shared two-port memory. It gives each side a doorbell that the other side can ring. Two addresses at the top of the memory act as mailboxes, one for each direction. The highest address carries messages from the left side to the right. The address just below it carries messages from the right side to the left.

When a side stores a word in its outbound mailbox, the block lowers the interrupt line of the other side. That line stays low until the receiving side reads the mailbox. The read tells the block that the message was consumed, and the line is released.

The block only watches each side's memory control pins: select, write strobe, output enable and address. It does not hold the data, arbitrate between the ports or drive the pads. Both interrupt lines are registered and active-low. All enables are active-low. `rst` is synchronous and active-high.

Top module: `mbx_irq_top`

## Requirements
- R1: While `rst` is high at a clock edge, both `l_irq_n` and `r_irq_n` read 1 after that edge.
- R2: A left write lowers `r_irq_n` after the clock edge that samples it. A left write means `l_cs_n`=0 and `l_we_n`=0, at `l_addr` equal to all ones (0x7FF for 11 bits).
- R3: A right read raises `r_irq_n` after the sampling edge. A right read means `r_cs_n`=0, `r_oe_n`=0 and `r_we_n`=1, at `r_addr` equal to all ones.
- R4: A right write lowers `l_irq_n` after the sampling edge. A right write means `r_cs_n`=0 and `r_we_n`=0, at `r_addr` equal to all ones minus one (0x7FE).
- R5: A left read raises `l_irq_n` after the sampling edge. A left read means `l_cs_n`=0, `l_oe_n`=0 and `l_we_n`=1, at `l_addr` equal to all ones minus one.
- R6: Some accesses cannot lower a flag: a write with select or strobe high, a write to any other address, or a write by a side to its own inbound mailbox.
- R7: Some accesses cannot raise a low flag:
  - a read with select or output enable high;
  - an access with `we_n`=0;
  - a read of any other address;
  - a read by the side that sent the message.
- R8: If a qualifying write and a qualifying read of the same mailbox are sampled at the same edge, the flag is low after that edge.
- R9: Once low, a flag stays low across further writes to the same mailbox. Only a qualifying read raises it.
- R10: The two flags are independent. Both can be set or cleared at the same edge, and activity on one mailbox leaves the other flag unchanged.
- R11: The flags are registered. A qualifying access changes no output before the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active-high |
| l_cs_n | input | 1 | Left select, active-low |
| l_we_n | input | 1 | Left write strobe, active-low |
| l_oe_n | input | 1 | Left output enable, active-low |
| l_addr | input | ADDR_W | Left address |
| r_cs_n | input | 1 | Right select, active-low |
| r_we_n | input | 1 | Right write strobe, active-low |
| r_oe_n | input | 1 | Right output enable, active-low |
| r_addr | input | ADDR_W | Right address |
| l_irq_n | output | 1 | Left interrupt, active-low |
| r_irq_n | output | 1 | Right interrupt, active-low |

## Verification
A sender can post a new message in the same cycle that the receiver reads the previous one. That makes a set and a clear of one flag land on one clock edge. The bench provokes this for both directions by driving the sender's write and the receiver's read in the same vector. It judges the result correct only if the flag is low after that edge, so the new message is not lost. The bench also drives writes to both mailboxes, and reads of both, in single cycles to show that the two flags never disturb each other.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t kind;
        logic      hit_outbox;
        logic      hit_inbox;
    } port_evt_t;

    localparam int unsigned NUM_SIDES = 2;
    localparam int unsigned SIDE_L    = 0;
    localparam int unsigned SIDE_R    = 1;

    // Classify one side's strobes; a write wins over an enabled output.
    function automatic acc_kind_t classify(input logic cs_n, input logic we_n, input logic oe_n);
        if (cs_n)
            return ACC_IDLE;
        else if (!we_n)
            return ACC_WRITE;
        else if (!oe_n)
            return ACC_READ;
        else
            return ACC_IDLE;
    endfunction

    function automatic int unsigned peer_of(input int unsigned side);
        return (side == SIDE_L) ? SIDE_R : SIDE_L;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11,
    parameter logic [ADDR_W-1:0] OUTBOX = '1,
    parameter logic [ADDR_W-1:0] INBOX  = '1
) (
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output port_evt_t         evt
);

    always_comb begin
        evt.kind       = classify(cs_n, we_n, oe_n);
        evt.hit_outbox = (addr == OUTBOX);
        evt.hit_inbox  = (addr == INBOX);
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_req,
    input  logic clr_req,
    output logic pending_q
);

    logic pending_d;

    // Posting wins over consuming so a fresh message survives.
    always_comb begin
        pending_d = pending_q;
        if (clr_req)
            pending_d = 1'b0;
        if (set_req)
            pending_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pending_q <= 1'b0;
        else
            pending_q <= pending_d;
    end

endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_cs_n,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_cs_n,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] BOX_TO_R = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BOX_TO_L = BOX_TO_R - 1'b1;

    logic [NUM_SIDES-1:0]              cs_n_v, we_n_v, oe_n_v;
    logic [NUM_SIDES-1:0][ADDR_W-1:0]  addr_v;
    port_evt_t [NUM_SIDES-1:0]         evt_v;
    logic [NUM_SIDES-1:0]              pending_v;

    always_comb begin
        cs_n_v[SIDE_L] = l_cs_n;
        we_n_v[SIDE_L] = l_we_n;
        oe_n_v[SIDE_L] = l_oe_n;
        addr_v[SIDE_L] = l_addr;
        cs_n_v[SIDE_R] = r_cs_n;
        we_n_v[SIDE_R] = r_we_n;
        oe_n_v[SIDE_R] = r_oe_n;
        addr_v[SIDE_R] = r_addr;
    end

    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
        localparam logic [ADDR_W-1:0] MY_OUT = (s == SIDE_L) ? BOX_TO_R : BOX_TO_L;
        localparam logic [ADDR_W-1:0] MY_IN  = (s == SIDE_L) ? BOX_TO_L : BOX_TO_R;
        localparam int unsigned       PEER   = peer_of(s);

        logic set_req, clr_req;

        mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .OUTBOX (MY_OUT),
            .INBOX  (MY_IN)
        ) u_dec (
            .cs_n (cs_n_v[s]),
            .we_n (we_n_v[s]),
            .oe_n (oe_n_v[s]),
            .addr (addr_v[s]),
            .evt  (evt_v[s])
        );

        // Flag s belongs to the receiving side s.
        assign set_req = (evt_v[PEER].kind == ACC_WRITE) && evt_v[PEER].hit_outbox;
        assign clr_req = (evt_v[s].kind == ACC_READ) && evt_v[s].hit_inbox;

        mbx_flag u_flag (
            .clk       (clk),
            .rst       (rst),
            .set_req   (set_req),
            .clr_req   (clr_req),
            .pending_q (pending_v[s])
        );
    end

    assign l_irq_n = ~pending_v[SIDE_L];
    assign r_irq_n = ~pending_v[SIDE_R];

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              l_cs_n,
    input logic              l_we_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_cs_n,
    input logic              r_we_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    logic post_to_r, post_to_l, take_r, take_l;
    assign post_to_r = !(l_cs_n | l_we_n) && (&l_addr);
    assign post_to_l = !(r_cs_n | r_we_n) && (r_addr == {{(ADDR_W-1){1'b1}}, 1'b0});
    assign take_r    = !(r_cs_n | r_oe_n) && r_we_n && (&r_addr);
    assign take_l    = !(l_cs_n | l_oe_n) && l_we_n && (l_addr == {{(ADDR_W-1){1'b1}}, 1'b0});

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (l_irq_n && r_irq_n));
    // R2
    post_r_chk: assert property (@(posedge clk) disable iff (rst) post_to_r |=> !r_irq_n);
    // R4
    post_l_chk: assert property (@(posedge clk) disable iff (rst) post_to_l |=> !l_irq_n);
    // R3
    take_r_chk: assert property (@(posedge clk) disable iff (rst) (take_r && !post_to_r) |=> r_irq_n);
    // R5
    take_l_chk: assert property (@(posedge clk) disable iff (rst) (take_l && !post_to_l) |=> l_irq_n);
    // R6
    quiet_r_chk: assert property (@(posedge clk) disable iff (rst) (r_irq_n && !post_to_r) |=> r_irq_n);
    // R6
    quiet_l_chk: assert property (@(posedge clk) disable iff (rst) (l_irq_n && !post_to_l) |=> l_irq_n);
    // R9
    hold_r_chk: assert property (@(posedge clk) disable iff (rst) (!r_irq_n && !take_r) |=> !r_irq_n);
    // R9
    hold_l_chk: assert property (@(posedge clk) disable iff (rst) (!l_irq_n && !take_l) |=> !l_irq_n);
    // R8
    clash_r_chk: assert property (@(posedge clk) disable iff (rst) (post_to_r && take_r) |=> !r_irq_n);

endmodule

bind mbx_irq_top mbx_irq_chk #(.ADDR_W(ADDR_W)) u_mbx_irq_chk (.*);

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;

    localparam int unsigned AW = 11;
    localparam logic [AW-1:0] TOP = 11'h7FF;
    localparam logic [AW-1:0] NXT = 11'h7FE;
    localparam logic [AW-1:0] OTH = 11'h123;

    typedef struct packed {
        logic          lcs, lwe, loe;
        logic [AW-1:0] la;
        logic          rcs, rwe, roe;
        logic [AW-1:0] ra;
        logic          exp_l, exp_r;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,1'b1,TOP, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b0, 4'd2},  // R2 left posts
        '{1'b0,1'b0,1'b1,TOP, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b0, 4'd9},  // R9 repeat post
        '{1'b1,1'b1,1'b1,OTH, 1'b0,1'b1,1'b0,NXT, 1'b1,1'b0, 4'd7},  // R7 wrong box read
        '{1'b1,1'b1,1'b1,OTH, 1'b0,1'b0,1'b0,TOP, 1'b1,1'b0, 4'd7},  // R7 strobe low
        '{1'b1,1'b1,1'b1,OTH, 1'b1,1'b1,1'b0,TOP, 1'b1,1'b0, 4'd7},  // R7 select high
        '{1'b1,1'b1,1'b1,OTH, 1'b0,1'b1,1'b0,TOP, 1'b1,1'b1, 4'd3},  // R3 right takes
        '{1'b1,1'b0,1'b1,TOP, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b1, 4'd6},  // R6 select high
        '{1'b0,1'b1,1'b1,TOP, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b1, 4'd6},  // R6 strobe high
        '{1'b0,1'b0,1'b1,NXT, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b1, 4'd6},  // R6 own inbox
        '{1'b1,1'b1,1'b1,OTH, 1'b0,1'b0,1'b1,NXT, 1'b0,1'b1, 4'd4},  // R4 right posts
        '{1'b0,1'b1,1'b0,TOP, 1'b1,1'b1,1'b1,OTH, 1'b0,1'b1, 4'd7},  // R7 sender reads
        '{1'b0,1'b1,1'b0,NXT, 1'b1,1'b1,1'b1,OTH, 1'b1,1'b1, 4'd5},  // R5 left takes
        '{1'b0,1'b0,1'b1,TOP, 1'b0,1'b0,1'b1,NXT, 1'b0,1'b0, 4'd10}, // R10 both post
        '{1'b0,1'b1,1'b0,NXT, 1'b0,1'b0,1'b1,NXT, 1'b0,1'b0, 4'd8},  // R8 left clash
        '{1'b0,1'b0,1'b1,TOP, 1'b0,1'b1,1'b0,TOP, 1'b0,1'b0, 4'd8},  // R8 right clash
        '{1'b0,1'b1,1'b0,NXT, 1'b0,1'b1,1'b0,TOP, 1'b1,1'b1, 4'd10}, // R10 both take
        '{1'b1,1'b1,1'b1,OTH, 1'b0,1'b0,1'b1,11'h7FD, 1'b1,1'b1, 4'd6} // R6 other address
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_cs_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1;
    logic r_cs_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mbx_irq_top #(.ADDR_W(AW)) i_mbx_irq_top (.*);

    task automatic check(input string tag, input logic al, input logic ar,
                         input logic el, input logic er);
        n_chk++;
        if (al !== el || ar !== er) begin
            n_err++;
            $display("FAIL %s: irq l/r actual=%b%b expected=%b%b", tag, al, ar, el, er);
        end
    endtask

    task automatic idle();
        l_cs_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1; l_addr = OTH;
        r_cs_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1; r_addr = OTH;
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", l_irq_n, r_irq_n, 1'b1, 1'b1);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {l_cs_n, l_we_n, l_oe_n, l_addr} = {VEC[i].lcs, VEC[i].lwe, VEC[i].loe, VEC[i].la};
            {r_cs_n, r_we_n, r_oe_n, r_addr} = {VEC[i].rcs, VEC[i].rwe, VEC[i].roe, VEC[i].ra};
            @(posedge clk);
            #2;
            check($sformatf("R%0d vector %0d", VEC[i].req, i), l_irq_n, r_irq_n,
                  VEC[i].exp_l, VEC[i].exp_r);
        end

        // R11: flags are registered, no change before the edge
        @(negedge clk) idle();
        @(negedge clk);
        l_cs_n = 1'b0; l_we_n = 1'b0; l_addr = TOP;
        #3;
        check("R11 before edge", l_irq_n, r_irq_n, 1'b1, 1'b1);
        @(posedge clk);
        #2;
        check("R11 after edge", l_irq_n, r_irq_n, 1'b1, 1'b0);

        // R9: idle cycles keep the flag low
        @(negedge clk) idle();
        repeat (3) @(posedge clk);
        #2;
        check("R9 held while idle", l_irq_n, r_irq_n, 1'b1, 1'b0);

        // R1: reset releases a pending flag
        @(negedge clk);
        r_cs_n = 1'b0; r_we_n = 1'b0; r_addr = NXT;
        @(posedge clk);
        #2;
        check("R4 before reset", l_irq_n, r_irq_n, 1'b0, 1'b0);
        @(negedge clk) begin idle(); rst = 1'b1; end
        @(posedge clk);
        #2;
        check("R1 reset clears", l_irq_n, r_irq_n, 1'b1, 1'b1);
        @(negedge clk) rst = 1'b0;

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule